// File: doc/BRIEF.md
# Checksummed Debug Packet Receiver

This block sits behind a serial byte link and extracts framed debug packets from the incoming stream. A frame opens with `$` (0x24), carries a payload and closes with `#` (0x23), followed by two hex digits that give the 8-bit sum of the payload bytes. The block checks the received checksum against its own running sum. It answers each complete frame with a single acknowledge byte on its transmit port: `+` for a good frame and `-` for a bad one.

Accepted payloads are stored in an internal byte buffer. The consumer is told about them through `pkt_valid_o` and `pkt_len_o`, reads the bytes through a random-access read port, and frees the buffer with `pkt_ack_i`. A payload may begin with a two-character sequence tag followed by `:`. In that case the tag is echoed back right after the `+`, and the three leading bytes are hidden from the consumer.

Both byte streams use a valid/ready handshake. Only one direction is ever live at a time: the receive side stalls while an acknowledge is being sent and while a packet is pending.

Top module: `dbg_pkt_rx`

## Requirements
- R1: After reset `rx_ready_o` is 1, and `tx_valid_o` and `pkt_valid_o` are 0.
- R2: Every byte other than `$` (0x24) that arrives while no frame is open is dropped. It produces no transmit byte and no packet.
- R3: A frame whose two checksum digits (high nibble first, `0`-`9`, `a`-`f` or `A`-`F`) equal the modulo-256 sum of its payload is answered with `+` (0x2B). Its payload is then delivered with `pkt_len_o` equal to its byte count, and byte i is read at `rd_addr_i` = i. The sum excludes `$` and `#`.
- R4: A frame whose checksum does not match is answered with `-` (0x2D). No packet is delivered, and the block resumes hunting for `$`.
- R5: A checksum position holding a character that is not a hex digit counts as a mismatch and is answered with `-`.
- R6: With buffer depth DEPTH, the payload byte that would become the DEPTH-th byte before `#` drops the frame. No acknowledge is sent and hunting restarts. A payload of DEPTH-1 bytes is still accepted.
- R7: A `$` inside a payload restarts the frame, discarding the sum and the bytes gathered so far.
- R8: If an accepted payload has at least 3 bytes and its byte at index 2 is `:` (0x3A), the transmit port sends `+`, then byte 0, then byte 1. The delivered packet then starts at payload byte 3, with `pkt_len_o` equal to the payload length minus 3.
- R9: `pkt_valid_o` and `pkt_len_o` hold steady until `pkt_ack_i`, and `rx_ready_o` stays 0 while a packet is pending.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold.
- R11: `rx_ready_o` is 0 whenever `tx_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Incoming link byte |
| rx_valid_i | input | 1 | Incoming byte present |
| rx_ready_o | output | 1 | Block accepts the incoming byte |
| tx_data_o | output | 8 | Acknowledge or echoed tag byte |
| tx_valid_o | output | 1 | Transmit byte present |
| tx_ready_i | input | 1 | Link takes the transmit byte |
| pkt_valid_o | output | 1 | Delivered packet pending |
| pkt_len_o | output | $clog2(DEPTH) | Delivered payload length |
| rd_addr_i | input | $clog2(DEPTH) | Payload read index |
| rd_data_o | output | 8 | Payload byte at the read index |
| pkt_ack_i | input | 1 | Consumer releases the packet |

## Verification
The frame parser is driven by random printable payloads of random length. Their checksums are written in either letter case, and some are deliberately wrong, which separates correct summing and case-blind digit decoding from off-by-one or case-sensitive faults. Directed streams cover leading garbage, a non-hex checksum digit, a restart by `$` mid-payload, payload lengths at DEPTH-1 and DEPTH, and tag prefixes of exactly three and of two bytes. These show whether hunting, restart, overflow and tag stripping act at the right byte. Random gaps on both valid and ready, together with a delayed packet release, expose any handshake that loses or repeats a byte.

// File: rtl/dbg_pkt_pkg.sv
package dbg_pkt_pkg;
  localparam logic [7:0] CH_SOF   = 8'h24;
  localparam logic [7:0] CH_EOF   = 8'h23;
  localparam logic [7:0] CH_ACK   = 8'h2B;
  localparam logic [7:0] CH_NAK   = 8'h2D;
  localparam logic [7:0] CH_COLON = 8'h3A;

  typedef enum logic [2:0] {
    S_HUNT, S_BODY, S_CKHI, S_CKLO, S_ACK, S_SEQ0, S_SEQ1, S_HOLD
  } rx_state_e;
endpackage

// File: rtl/dbg_pkt_hexdec.sv
module dbg_pkt_hexdec (
  input  logic [7:0] ch_i,
  output logic [3:0] nib_o,
  output logic       ok_o
);
  always_comb begin
    ok_o  = 1'b1;
    nib_o = 4'h0;
    if (ch_i >= 8'h30 && ch_i <= 8'h39)
      nib_o = ch_i[3:0];
    else if ((ch_i >= 8'h61 && ch_i <= 8'h66) || (ch_i >= 8'h41 && ch_i <= 8'h46))
      nib_o = ch_i[3:0] + 4'd9;
    else
      ok_o = 1'b0;
  end
endmodule

// File: rtl/dbg_pkt_buf.sv
module dbg_pkt_buf #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          strip_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] rd_phys;

  always_ff @(posedge clk_i)
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;

  // tag prefix hidden by offsetting reads
  assign rd_phys   = rd_addr_i + (strip_i ? AW'(3) : AW'(0));
  assign rd_data_o = mem_q[rd_phys];
endmodule

// File: rtl/dbg_pkt_fsm.sv
module dbg_pkt_fsm
  import dbg_pkt_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          pkt_valid_o,
  output logic [AW-1:0] pkt_len_o,
  input  logic          pkt_ack_i,
  input  logic [3:0]    nib_i,
  input  logic          nib_ok_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          strip_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  rx_state_e     state_q;
  logic [AW-1:0] cnt_q;
  logic [7:0]    sum_q;
  logic [3:0]    hi_q;
  logic          hi_ok_q, good_q, seq_q;
  logic [7:0]    id0_q, id1_q, id2_q;
  logic          take, is_data, ck_ok, seq_hit;

  assign rx_ready_o = (state_q == S_HUNT) || (state_q == S_BODY) ||
                      (state_q == S_CKHI) || (state_q == S_CKLO);
  assign take       = rx_valid_i && rx_ready_o;
  assign is_data    = (rx_data_i != CH_SOF) && (rx_data_i != CH_EOF);
  assign ck_ok      = hi_ok_q && nib_ok_i && ({hi_q, nib_i} == sum_q);
  assign seq_hit    = (cnt_q >= AW'(3)) && (id2_q == CH_COLON);

  assign wr_en_o    = take && (state_q == S_BODY) && is_data && (cnt_q != LAST);
  assign wr_addr_o  = cnt_q;
  assign strip_o    = seq_q;

  assign tx_valid_o  = (state_q == S_ACK) || (state_q == S_SEQ0) || (state_q == S_SEQ1);
  assign pkt_valid_o = (state_q == S_HOLD);
  assign pkt_len_o   = seq_q ? cnt_q - AW'(3) : cnt_q;

  always_comb begin
    case (state_q)
      S_ACK:   tx_data_o = good_q ? CH_ACK : CH_NAK;
      S_SEQ0:  tx_data_o = id0_q;
      S_SEQ1:  tx_data_o = id1_q;
      default: tx_data_o = 8'h00;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HUNT;
      cnt_q   <= '0;
      sum_q   <= '0;
      hi_q    <= '0;
      hi_ok_q <= 1'b0;
      good_q  <= 1'b0;
      seq_q   <= 1'b0;
      id0_q   <= '0;
      id1_q   <= '0;
      id2_q   <= '0;
    end else begin
      case (state_q)
        S_HUNT: if (take && rx_data_i == CH_SOF) begin
          state_q <= S_BODY;
          cnt_q   <= '0;
          sum_q   <= '0;
        end
        S_BODY: if (take) begin
          if (rx_data_i == CH_SOF) begin
            cnt_q <= '0;
            sum_q <= '0;
          end else if (rx_data_i == CH_EOF) begin
            state_q <= S_CKHI;
          end else if (cnt_q == LAST) begin
            state_q <= S_HUNT;  // overflow: silent drop
          end else begin
            cnt_q <= cnt_q + AW'(1);
            sum_q <= sum_q + rx_data_i;
            if (cnt_q == AW'(0)) id0_q <= rx_data_i;
            if (cnt_q == AW'(1)) id1_q <= rx_data_i;
            if (cnt_q == AW'(2)) id2_q <= rx_data_i;
          end
        end
        S_CKHI: if (take) begin
          hi_q    <= nib_i;
          hi_ok_q <= nib_ok_i;
          state_q <= S_CKLO;
        end
        S_CKLO: if (take) begin
          good_q  <= ck_ok;
          seq_q   <= ck_ok && seq_hit;
          state_q <= S_ACK;
        end
        S_ACK: if (tx_ready_i)
          state_q <= !good_q ? S_HUNT : (seq_q ? S_SEQ0 : S_HOLD);
        S_SEQ0: if (tx_ready_i) state_q <= S_SEQ1;
        S_SEQ1: if (tx_ready_i) state_q <= S_HOLD;
        S_HOLD: if (pkt_ack_i) begin
          state_q <= S_HUNT;
          seq_q   <= 1'b0;
        end
        default: state_q <= S_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/dbg_pkt_rx.sv
module dbg_pkt_rx #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    rx_data_i,
  input  logic          rx_valid_i,
  output logic          rx_ready_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic          pkt_valid_o,
  output logic [AW-1:0] pkt_len_o,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  input  logic          pkt_ack_i
);
  logic [3:0]    nib;
  logic          nib_ok, wr_en, strip;
  logic [AW-1:0] wr_addr;

  if (DEPTH < 4) begin : g_bad_depth
    initial $error("DEPTH must be at least 4");
  end

  dbg_pkt_hexdec u_hex (
    .ch_i  (rx_data_i),
    .nib_o (nib),
    .ok_o  (nib_ok)
  );

  dbg_pkt_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_data_i   (rx_data_i),
    .rx_valid_i  (rx_valid_i),
    .rx_ready_o  (rx_ready_o),
    .tx_data_o   (tx_data_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .pkt_valid_o (pkt_valid_o),
    .pkt_len_o   (pkt_len_o),
    .pkt_ack_i   (pkt_ack_i),
    .nib_i       (nib),
    .nib_ok_i    (nib_ok),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .strip_o     (strip)
  );

  dbg_pkt_buf #(.DEPTH(DEPTH)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (rx_data_i),
    .rd_addr_i (rd_addr_i),
    .strip_i   (strip),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/dbg_pkt_rx_chk.sv
module dbg_pkt_rx_chk #(
  parameter int AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rx_ready_o,
  input logic [7:0]    tx_data_o,
  input logic          tx_valid_o,
  input logic          tx_ready_i,
  input logic          pkt_valid_o,
  input logic [AW-1:0] pkt_len_o,
  input logic          pkt_ack_i
);
  always_ff @(posedge clk_i)
    if (!rst_ni) a_r1_reset_idle: assert (!tx_valid_o && !pkt_valid_o && rx_ready_o);

  a_r9_pkt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && !pkt_ack_i |=> pkt_valid_o && $stable(pkt_len_o));

  a_r9_ack_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o && pkt_ack_i |=> !pkt_valid_o && rx_ready_o);

  a_r9_rx_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> !rx_ready_o);

  a_r10_tx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  a_r11_tx_blocks_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !rx_ready_o && !pkt_valid_o);
endmodule

bind dbg_pkt_rx dbg_pkt_rx_chk #(.AW(AW)) chk_i (.*);

// File: tb/dbg_pkt_rx_tb_top.sv
module dbg_pkt_rx_tb_top;
  localparam int DEPTH = 2048;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni;
  logic [7:0]    rx_data_i;
  logic          rx_valid_i, rx_ready_o;
  logic [7:0]    tx_data_o;
  logic          tx_valid_o, tx_ready_i;
  logic          pkt_valid_o, pkt_ack_i;
  logic [AW-1:0] pkt_len_o, rd_addr_i;
  logic [7:0]    rd_data_o;

  dbg_pkt_rx #(.DEPTH(DEPTH)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i),
    .rx_ready_o(rx_ready_o), .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .pkt_valid_o(pkt_valid_o), .pkt_len_o(pkt_len_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .pkt_ack_i(pkt_ack_i)
  );

  int  checks = 0, fails = 0, cyc = 0;
  bit  timed_out = 1'b0;
  byte exp_tx[$], got_tx[$], exp_pd[$], got_pd[$];
  int  exp_len[$], got_len[$];

  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hexv(input byte c);
    if (c >= "0" && c <= "9") return int'(c) - 48;
    if (c >= "a" && c <= "f") return int'(c) - 87;
    if (c >= "A" && c <= "F") return int'(c) - 55;
    return -1;
  endfunction

  function automatic byte nib2ch(input int n, input bit up);
    if (n < 10) return byte'(48 + n);
    return byte'((up ? 55 : 87) + n);
  endfunction

  // expected link replies and packets, from the requirements
  function automatic void model(input byte s[$]);
    int  st = 0, sum = 0, hi = 0, lo;
    byte pl[$];
    foreach (s[k]) begin
      byte c = s[k];
      case (st)
        0: if (c == "$") begin st = 1; sum = 0; pl.delete(); end
        1: if (c == "$") begin sum = 0; pl.delete(); end
           else if (c == "#") st = 2;
           else if (pl.size() == DEPTH - 1) st = 0;
           else begin pl.push_back(c); sum = (sum + int'(c) & 255) & 255; end
        2: begin hi = hexv(c); st = 3; end
        default: begin
          lo = hexv(c);
          st = 0;
          if (hi >= 0 && lo >= 0 && hi * 16 + lo == sum) begin
            exp_tx.push_back("+");
            if (pl.size() >= 3 && pl[2] == ":") begin
              exp_tx.push_back(pl[0]);
              exp_tx.push_back(pl[1]);
              exp_len.push_back(pl.size() - 3);
              for (int j = 3; j < pl.size(); j++) exp_pd.push_back(pl[j]);
            end else begin
              exp_len.push_back(pl.size());
              foreach (pl[j]) exp_pd.push_back(pl[j]);
            end
          end else exp_tx.push_back("-");
        end
      endcase
    end
  endfunction

  function automatic void add_frame(ref byte q[$], input byte p[$], input bit up, input int delta);
    int sum = 0;
    foreach (p[k]) sum = (sum + (int'(p[k]) & 255)) & 255;
    sum = (sum + delta) & 255;
    q.push_back("$");
    foreach (p[k]) q.push_back(p[k]);
    q.push_back("#");
    q.push_back(nib2ch(sum >> 4, up));
    q.push_back(nib2ch(sum & 15, up));
  endfunction

  task automatic run(input byte s[$], input string tag);
    int  idx = 0, idle = 0, rd_idx = 0;
    bit  prev_stall = 1'b0, v9 = 1'b0, v10 = 1'b0, v11 = 1'b0;
    byte prev_data = 0;
    exp_tx.delete(); got_tx.delete(); exp_pd.delete(); got_pd.delete();
    exp_len.delete(); got_len.delete();
    model(s);
    while (idle < 4 && !timed_out) begin
      @(negedge clk);
      if (cyc > 190000) timed_out = 1'b1;
      if (prev_stall && !(tx_valid_o && tx_data_o == prev_data)) v10 = 1'b1;
      if (pkt_valid_o && rx_ready_o) v9 = 1'b1;
      if (tx_valid_o && rx_ready_o) v11 = 1'b1;
      pkt_ack_i = 1'b0;
      if (pkt_valid_o) begin
        if (rd_idx < int'(pkt_len_o)) begin
          rd_addr_i = AW'(rd_idx);
          #1;
          got_pd.push_back(byte'(rd_data_o));
          rd_idx++;
        end else if ($urandom % 2 == 0) begin
          pkt_ack_i = 1'b1;
          got_len.push_back(int'(pkt_len_o));
          rd_idx = 0;
        end
      end
      tx_ready_i = ($urandom % 4) != 0;
      if (tx_valid_o && tx_ready_i) got_tx.push_back(byte'(tx_data_o));
      prev_stall = tx_valid_o && !tx_ready_i;
      prev_data  = byte'(tx_data_o);
      rx_valid_i = 1'b0;
      if (idx < s.size() && ($urandom % 4) != 0) begin
        rx_valid_i = 1'b1;
        rx_data_i  = s[idx];
        if (rx_ready_o) idx++;
      end
      idle = (idx == s.size() && rx_ready_o && !tx_valid_o && !pkt_valid_o) ? idle + 1 : 0;
    end
    @(negedge clk);
    rx_valid_i = 1'b0;
    pkt_ack_i  = 1'b0;
    tx_ready_i = 1'b0;
    check(got_tx.size() == exp_tx.size(), {tag, " reply count"}, got_tx.size(), exp_tx.size());
    foreach (exp_tx[k])
      if (k < got_tx.size()) check(got_tx[k] == exp_tx[k], {tag, " reply byte"}, got_tx[k], exp_tx[k]);
    check(got_len.size() == exp_len.size(), {tag, " packet count"}, got_len.size(), exp_len.size());
    foreach (exp_len[k])
      if (k < got_len.size()) check(got_len[k] == exp_len[k], {tag, " packet length"}, got_len[k], exp_len[k]);
    check(got_pd.size() == exp_pd.size(), {tag, " payload size"}, got_pd.size(), exp_pd.size());
    for (int k = 0; k < exp_pd.size() && k < got_pd.size(); k++)
      if (got_pd[k] != exp_pd[k]) begin
        check(1'b0, {tag, " payload byte"}, got_pd[k], exp_pd[k]);
        break;
      end
    check(!v9, "R9 input stalled while packet pending", v9, 0);
    check(!v10, "R10 transmit byte held under backpressure", v10, 0);
    check(!v11, "R11 no receive during transmit", v11, 0);
  endtask

  function automatic void str2q(ref byte q[$], input string s);
    for (int k = 0; k < s.len(); k++) q.push_back(byte'(s[k]));
  endfunction

  initial begin
    byte s[$], p[$];
    void'($urandom(32'd20240611));
    rst_ni = 1'b0; rx_valid_i = 1'b0; rx_data_i = '0; tx_ready_i = 1'b0;
    pkt_ack_i = 1'b0; rd_addr_i = '0;
    repeat (3) @(negedge clk);
    check(rx_ready_o == 1'b1, "R1 ready after reset", rx_ready_o, 1);
    check(tx_valid_o == 1'b0, "R1 no transmit after reset", tx_valid_o, 0);
    check(pkt_valid_o == 1'b0, "R1 no packet after reset", pkt_valid_o, 0);
    rst_ni = 1'b1;

    // R2 garbage, then lower-case good frame (R3)
    s.delete(); str2q(s, "xyz#12+-"); p.delete(); str2q(p, "abc"); add_frame(s, p, 0, 0);
    run(s, "R2 R3 garbage then frame");
    // R3 upper-case digits
    s.delete(); p.delete(); str2q(p, "zzzz~~~"); add_frame(s, p, 1, 0);
    run(s, "R3 upper case checksum");
    // R4 wrong checksum, then a good frame
    s.delete(); p.delete(); str2q(p, "bad"); add_frame(s, p, 0, 1);
    p.delete(); str2q(p, "ok"); add_frame(s, p, 0, 0);
    run(s, "R4 mismatch");
    // R5 non-hex digit
    s.delete(); str2q(s, "$q#g1$q#G1");
    run(s, "R5 non-hex checksum");
    // R7 restart mid-payload
    s.delete(); str2q(s, "$ab"); p.delete(); str2q(p, "cd"); add_frame(s, p, 0, 0);
    run(s, "R7 restart");
    // R8 tag prefixes: exact 3 bytes, longer, and too short
    s.delete(); p.delete(); str2q(p, "07:"); add_frame(s, p, 0, 0);
    p.delete(); str2q(p, "1f:read"); add_frame(s, p, 1, 0);
    p.delete(); str2q(p, "a:"); add_frame(s, p, 0, 0);
    p.delete(); add_frame(s, p, 0, 0);
    run(s, "R8 tag strip");
    // R6 boundary: DEPTH-1 accepted, DEPTH dropped
    s.delete(); p.delete();
    for (int k = 0; k < DEPTH - 1; k++) p.push_back(byte'(33 + k % 2));
    add_frame(s, p, 0, 0);
    run(s, "R6 longest accepted payload");
    s.delete(); p.delete();
    for (int k = 0; k < DEPTH; k++) p.push_back("w");
    add_frame(s, p, 0, 0);
    p.delete(); str2q(p, "after"); add_frame(s, p, 0, 0);
    run(s, "R6 overflow drop");

    // random frames
    for (int n = 0; n < 40; n++) begin
      int len = $urandom % 40;
      s.delete(); p.delete();
      for (int k = 0; k < len; k++) begin
        byte c;
        do c = byte'(32 + $urandom % 95); while (c == "$" || c == "#");
        p.push_back(c);
      end
      if (len >= 3 && $urandom % 3 == 0) p[2] = ":";
      if ($urandom % 3 == 0) str2q(s, "~x");
      add_frame(s, p, $urandom % 2, ($urandom % 5 == 0) ? 1 + $urandom % 255 : 0);
      run(s, "R3 R4 R8 random frame");
    end

    check(!timed_out, "watchdog", timed_out, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule